// File: doc/BRIEF.md
# Synchronous Dual-Port Burst RAM

This block is a true dual-port synchronous static memory. It has two ports, A and B, and each port runs on its own clock. Each port has an address input, a write-data input, a read/write select, two chip enables of opposite polarity and an output enable. Both ports can reach every word at any time. Two ports may also read the same word in the same cycle.

Each port keeps its own address pointer. The pointer can take the external address, stay where it is, step to the next word for a burst, or return to zero. A port uses its pointer for the access in the cycle after the controls are captured. This lets a master set a start address once and then stream words on every clock.

A static mode input on each port sets the read latency. In flow-through mode, data follows the registered address directly. In pipelined mode, data passes through one more register. The bidirectional bus is split into a data output and a drive-enable flag, which the pad ring combines into a tri-state bus. While the flag is low the data output is held at zero.

Top module: `dual_burst_ram`

## Requirements
- R1: The array holds 2**AW words of DW bits (64K x 8 when AW=16, DW=8). A word written through either port can be read back through both ports, and both ports may read the same word in the same cycle.
- R2: Each port captures its inputs on the rising edge of its own clock. A write captured at edge k is stored at edge k+1. A flow-through read of that word on the other port shows the new value after edge k+1. A pipelined read stage loaded at edge k+1 still holds the old value.
- R3: If clr_n is high and ld_n is low at an edge, the pointer takes addr at that edge, whatever step_n is.
- R4: If step_n is low and both clr_n and ld_n are high, the pointer advances by one and wraps from 2**AW-1 to 0. If all three controls are high, the pointer holds.
- R5: If clr_n is low at an edge, the pointer goes to zero, whatever ld_n and step_n are.
- R6: With pipe low, a read captured at edge k shows its data on rdata from just after edge k. The data is the word at the pointer and follows later writes to that word.
- R7: With pipe high, a read captured at edge k shows its data from just after edge k+1. The data is the word as it stood at edge k+1, and it is held until the next pipelined read is captured.
- R8: A port is selected only when en_lo_n is 0 and en_hi is 1. A cycle captured while the port is deselected writes nothing and drives nothing.
- R9: rdrive is 1 exactly when read data is due (as in R6 and R7) and oe_n is low. oe_n acts at once, without a clock. While rdrive is 0, rdata is all zeros.
- R10: While arst_n is low, both pointers are zero and neither port drives. After arst_n rises, each port ignores its inputs for two edges of its own clock and begins capturing at the third edge.
- R11: Writes from both ports in the same cycle to different words are both stored. Writes from both ports to the same word in the same cycle leave that word undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_n | input | 1 | Asynchronous active-low reset for both ports |
| clk_a | input | 1 | Port A clock |
| addr_a | input | AW | Port A external address |
| ld_n_a | input | 1 | Port A pointer load, active low |
| step_n_a | input | 1 | Port A pointer increment, active low |
| clr_n_a | input | 1 | Port A pointer clear, active low |
| en_lo_n_a | input | 1 | Port A chip enable, active low |
| en_hi_a | input | 1 | Port A chip enable, active high |
| rnw_a | input | 1 | Port A read (1) or write (0) |
| oe_n_a | input | 1 | Port A output enable, active low |
| pipe_a | input | 1 | Port A latency mode: 0 flow-through, 1 pipelined |
| wdata_a | input | DW | Port A write data |
| rdata_a | output | DW | Port A read data, zero when not driven |
| rdrive_a | output | 1 | Port A bus drive enable |
| clk_b | input | 1 | Port B clock |
| addr_b | input | AW | Port B external address |
| ld_n_b | input | 1 | Port B pointer load, active low |
| step_n_b | input | 1 | Port B pointer increment, active low |
| clr_n_b | input | 1 | Port B pointer clear, active low |
| en_lo_n_b | input | 1 | Port B chip enable, active low |
| en_hi_b | input | 1 | Port B chip enable, active high |
| rnw_b | input | 1 | Port B read (1) or write (0) |
| oe_n_b | input | 1 | Port B output enable, active low |
| pipe_b | input | 1 | Port B latency mode: 0 flow-through, 1 pipelined |
| wdata_b | input | DW | Port B write data |
| rdata_b | output | DW | Port B read data, zero when not driven |
| rdrive_b | output | 1 | Port B bus drive enable |

## Verification
The array is first filled by a write burst on one port. Reads then run on both ports at once, one in each latency mode, and one burst crosses the top address. This separates off-by-one latency faults from faults in the increment and wrap of the pointer.

Other sequences cover the remaining behaviour:
- Load, clear and step are asserted together in several combinations, which exposes any change to the pointer's priority order.
- One port writes a burst while the other port reads the same words, which shows exactly when a stored value becomes visible.
- The two ports write separate bursts at the same time, which separates the two write paths.
- Each chip enable is turned off in turn during writes and reads, which proves that nothing is stored or driven.
- oe_n is toggled during held reads, which shows that the output enable is not clocked.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  // Operation applied to a port's address pointer at a clock edge.
  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_STEP = 2'd1,
    PTR_LOAD = 2'd2,
    PTR_ZERO = 2'd3
  } ptr_op_e;

  // Reset release: number of own-clock edges a port waits before capturing.
  localparam int unsigned RELEASE_STAGES = 2;

endpackage

// File: rtl/dbr_port_front.sv
module dbr_port_front
  import dbr_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic [AW-1:0] addr,
  input  logic          ld_n,
  input  logic          step_n,
  input  logic          clr_n,
  input  logic          en_lo_n,
  input  logic          en_hi,
  input  logic          rnw,
  input  logic [DW-1:0] wdata,
  output logic          run,
  output logic [AW-1:0] ptr,
  output logic          rd_go,
  output logic          wr_go,
  output logic [DW-1:0] wdata_q
);

  logic [RELEASE_STAGES-1:0] sync_q;
  ptr_op_e                   op;
  logic [AW-1:0]             ptr_d, ptr_q;
  logic                      sel_d, sel_q, rnw_q;
  logic                      wd_en;
  logic [DW-1:0]             wd_q;

  // Reset release chain: asynchronous assert, release after the chain fills.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[RELEASE_STAGES-2:0], 1'b1};
  end
  assign run = sync_q[RELEASE_STAGES-1];

  // Pointer operation: clear over load over step over hold.
  always_comb begin
    if (!clr_n)       op = PTR_ZERO;
    else if (!ld_n)   op = PTR_LOAD;
    else if (!step_n) op = PTR_STEP;
    else              op = PTR_HOLD;
  end

  always_comb begin
    unique case (op)
      PTR_ZERO: ptr_d = '0;
      PTR_LOAD: ptr_d = addr;
      PTR_STEP: ptr_d = ptr_q + AW'(1);
      default:  ptr_d = ptr_q;
    endcase
  end

  assign sel_d = !en_lo_n && en_hi;
  assign wd_en = sel_d && !rnw;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ptr_q <= '0;
      sel_q <= 1'b0;
      rnw_q <= 1'b1;
      wd_q  <= '0;
    end else if (!run) begin
      ptr_q <= '0;
      sel_q <= 1'b0;
      rnw_q <= 1'b1;
    end else begin
      ptr_q <= ptr_d;
      sel_q <= sel_d;
      rnw_q <= rnw;
      if (wd_en) wd_q <= wdata;
    end
  end

  assign ptr     = ptr_q;
  assign rd_go   = sel_q && rnw_q;
  assign wr_go   = sel_q && !rnw_q;
  assign wdata_q = wd_q;

endmodule

// File: rtl/dbr_xor_store.sv
module dbr_xor_store #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_a,
  input  logic          we_a,
  input  logic [AW-1:0] adr_a,
  input  logic [DW-1:0] wd_a,
  input  logic          clk_b,
  input  logic          we_b,
  input  logic [AW-1:0] adr_b,
  input  logic [DW-1:0] wd_b,
  output logic [DW-1:0] q_a,
  output logic [DW-1:0] q_b
);

  localparam int unsigned WORDS = 1 << AW;

  // Two halves, each written by one clock only; a word is the XOR of both.
  logic [DW-1:0] half_a [WORDS];
  logic [DW-1:0] half_b [WORDS];

  always_ff @(posedge clk_a) begin
    if (we_a) half_a[adr_a] <= wd_a ^ half_b[adr_a];
  end

  always_ff @(posedge clk_b) begin
    if (we_b) half_b[adr_b] <= wd_b ^ half_a[adr_b];
  end

  assign q_a = half_a[adr_a] ^ half_b[adr_a];
  assign q_b = half_a[adr_b] ^ half_b[adr_b];

endmodule

// File: rtl/dbr_read_out.sv
module dbr_read_out #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          run,
  input  logic          pipe,
  input  logic          rd_go,
  input  logic [DW-1:0] word,
  input  logic          oe_n,
  output logic [DW-1:0] rdata,
  output logic          rdrive
);

  logic          vld_q;
  logic [DW-1:0] dat_q;
  logic          vld;
  logic [DW-1:0] dat;

  // Extra output stage, used when the port is in pipelined mode.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (!run) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_go;
      if (rd_go) dat_q <= word;
    end
  end

  always_comb begin
    if (pipe) begin
      vld = vld_q;
      dat = dat_q;
    end else begin
      vld = rd_go;
      dat = word;
    end
  end

  assign rdrive = vld && !oe_n;
  assign rdata  = rdrive ? dat : '0;

endmodule

// File: rtl/dual_burst_ram.sv
module dual_burst_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          arst_n,
  input  logic          clk_a,
  input  logic [AW-1:0] addr_a,
  input  logic          ld_n_a,
  input  logic          step_n_a,
  input  logic          clr_n_a,
  input  logic          en_lo_n_a,
  input  logic          en_hi_a,
  input  logic          rnw_a,
  input  logic          oe_n_a,
  input  logic          pipe_a,
  input  logic [DW-1:0] wdata_a,
  output logic [DW-1:0] rdata_a,
  output logic          rdrive_a,
  input  logic          clk_b,
  input  logic [AW-1:0] addr_b,
  input  logic          ld_n_b,
  input  logic          step_n_b,
  input  logic          clr_n_b,
  input  logic          en_lo_n_b,
  input  logic          en_hi_b,
  input  logic          rnw_b,
  input  logic          oe_n_b,
  input  logic          pipe_b,
  input  logic [DW-1:0] wdata_b,
  output logic [DW-1:0] rdata_b,
  output logic          rdrive_b
);

  logic          run_a, run_b;
  logic [AW-1:0] ptr_a, ptr_b;
  logic          rd_go_a, rd_go_b, wr_go_a, wr_go_b;
  logic [DW-1:0] wdq_a, wdq_b, word_a, word_b;

  dbr_port_front #(.AW(AW), .DW(DW)) u_front_a (
    .clk(clk_a), .arst_n(arst_n), .addr(addr_a), .ld_n(ld_n_a),
    .step_n(step_n_a), .clr_n(clr_n_a), .en_lo_n(en_lo_n_a), .en_hi(en_hi_a),
    .rnw(rnw_a), .wdata(wdata_a), .run(run_a), .ptr(ptr_a),
    .rd_go(rd_go_a), .wr_go(wr_go_a), .wdata_q(wdq_a)
  );

  dbr_port_front #(.AW(AW), .DW(DW)) u_front_b (
    .clk(clk_b), .arst_n(arst_n), .addr(addr_b), .ld_n(ld_n_b),
    .step_n(step_n_b), .clr_n(clr_n_b), .en_lo_n(en_lo_n_b), .en_hi(en_hi_b),
    .rnw(rnw_b), .wdata(wdata_b), .run(run_b), .ptr(ptr_b),
    .rd_go(rd_go_b), .wr_go(wr_go_b), .wdata_q(wdq_b)
  );

  dbr_xor_store #(.AW(AW), .DW(DW)) u_store (
    .clk_a(clk_a), .we_a(wr_go_a), .adr_a(ptr_a), .wd_a(wdq_a),
    .clk_b(clk_b), .we_b(wr_go_b), .adr_b(ptr_b), .wd_b(wdq_b),
    .q_a(word_a), .q_b(word_b)
  );

  dbr_read_out #(.DW(DW)) u_out_a (
    .clk(clk_a), .arst_n(arst_n), .run(run_a), .pipe(pipe_a), .rd_go(rd_go_a),
    .word(word_a), .oe_n(oe_n_a), .rdata(rdata_a), .rdrive(rdrive_a)
  );

  dbr_read_out #(.DW(DW)) u_out_b (
    .clk(clk_b), .arst_n(arst_n), .run(run_b), .pipe(pipe_b), .rd_go(rd_go_b),
    .word(word_b), .oe_n(oe_n_b), .rdata(rdata_b), .rdrive(rdrive_b)
  );

endmodule

// File: rtl/dual_burst_ram_chk.sv
module dual_burst_ram_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input logic          arst_n,
  input logic          clk_a,
  input logic          run_a,
  input logic [AW-1:0] ptr_a,
  input logic [AW-1:0] addr_a,
  input logic          ld_n_a,
  input logic          step_n_a,
  input logic          clr_n_a,
  input logic          en_lo_n_a,
  input logic          en_hi_a,
  input logic          oe_n_a,
  input logic          pipe_a,
  input logic [DW-1:0] rdata_a,
  input logic          rdrive_a,
  input logic          clk_b,
  input logic          run_b,
  input logic [AW-1:0] ptr_b,
  input logic [AW-1:0] addr_b,
  input logic          ld_n_b,
  input logic          step_n_b,
  input logic          clr_n_b,
  input logic          en_lo_n_b,
  input logic          en_hi_b,
  input logic          oe_n_b,
  input logic          pipe_b,
  input logic [DW-1:0] rdata_b,
  input logic          rdrive_b
);

  // R5: clear wins over everything
  p_clear_a_r5: assert property (@(posedge clk_a) disable iff (!arst_n)
    !clr_n_a |=> ptr_a == '0);
  p_clear_b_r5: assert property (@(posedge clk_b) disable iff (!arst_n)
    !clr_n_b |=> ptr_b == '0);

  // R3: load takes the external address
  p_load_a_r3: assert property (@(posedge clk_a) disable iff (!arst_n)
    (run_a && clr_n_a && !ld_n_a) |=> ptr_a == $past(addr_a));
  p_load_b_r3: assert property (@(posedge clk_b) disable iff (!arst_n)
    (run_b && clr_n_b && !ld_n_b) |=> ptr_b == $past(addr_b));

  // R4: step and hold
  p_step_a_r4: assert property (@(posedge clk_a) disable iff (!arst_n)
    (run_a && clr_n_a && ld_n_a && !step_n_a) |=> ptr_a == AW'($past(ptr_a) + AW'(1)));
  p_step_b_r4: assert property (@(posedge clk_b) disable iff (!arst_n)
    (run_b && clr_n_b && ld_n_b && !step_n_b) |=> ptr_b == AW'($past(ptr_b) + AW'(1)));
  p_hold_a_r4: assert property (@(posedge clk_a) disable iff (!arst_n)
    (run_a && clr_n_a && ld_n_a && step_n_a) |=> $stable(ptr_a));
  p_hold_b_r4: assert property (@(posedge clk_b) disable iff (!arst_n)
    (run_b && clr_n_b && ld_n_b && step_n_b) |=> $stable(ptr_b));

  // R8: a deselected flow-through cycle drives nothing
  p_desel_a_r8: assert property (@(posedge clk_a) disable iff (!arst_n)
    (!pipe_a && (en_lo_n_a || !en_hi_a)) |=> !rdrive_a);
  p_desel_b_r8: assert property (@(posedge clk_b) disable iff (!arst_n)
    (!pipe_b && (en_lo_n_b || !en_hi_b)) |=> !rdrive_b);

  // R9: drive needs the output enable; idle data is zero
  p_oe_a_r9: assert property (@(posedge clk_a) disable iff (!arst_n)
    rdrive_a |-> !oe_n_a);
  p_oe_b_r9: assert property (@(posedge clk_b) disable iff (!arst_n)
    rdrive_b |-> !oe_n_b);
  p_quiet_a_r9: assert property (@(posedge clk_a) disable iff (!arst_n)
    !rdrive_a |-> rdata_a == '0);
  p_quiet_b_r9: assert property (@(posedge clk_b) disable iff (!arst_n)
    !rdrive_b |-> rdata_b == '0);

  // R10: no drive while a port is held in reset release
  p_release_a_r10: assert property (@(posedge clk_a) disable iff (!arst_n)
    !run_a |-> !rdrive_a);
  p_release_b_r10: assert property (@(posedge clk_b) disable iff (!arst_n)
    !run_b |-> !rdrive_b);

endmodule

bind dual_burst_ram dual_burst_ram_chk #(.AW(AW), .DW(DW)) u_chk (
  .arst_n(arst_n),
  .clk_a(clk_a), .run_a(run_a), .ptr_a(ptr_a), .addr_a(addr_a),
  .ld_n_a(ld_n_a), .step_n_a(step_n_a), .clr_n_a(clr_n_a),
  .en_lo_n_a(en_lo_n_a), .en_hi_a(en_hi_a), .oe_n_a(oe_n_a), .pipe_a(pipe_a),
  .rdata_a(rdata_a), .rdrive_a(rdrive_a),
  .clk_b(clk_b), .run_b(run_b), .ptr_b(ptr_b), .addr_b(addr_b),
  .ld_n_b(ld_n_b), .step_n_b(step_n_b), .clr_n_b(clr_n_b),
  .en_lo_n_b(en_lo_n_b), .en_hi_b(en_hi_b), .oe_n_b(oe_n_b), .pipe_b(pipe_b),
  .rdata_b(rdata_b), .rdrive_b(rdrive_b)
);

// File: tb/dual_burst_ram_test.sv
module dual_burst_ram_test;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          arst_n;
  logic [AW-1:0] i_addr [2];
  logic          i_ld_n [2], i_step_n [2], i_clr_n [2], i_enl_n [2], i_enh [2];
  logic          i_rnw [2], i_oe_n [2], i_pipe [2];
  logic [DW-1:0] i_wd [2];
  logic [DW-1:0] o_rd [2];
  logic          o_drv [2];

  dual_burst_ram #(.AW(AW), .DW(DW)) uut (
    .arst_n(arst_n),
    .clk_a(clk), .addr_a(i_addr[0]), .ld_n_a(i_ld_n[0]), .step_n_a(i_step_n[0]),
    .clr_n_a(i_clr_n[0]), .en_lo_n_a(i_enl_n[0]), .en_hi_a(i_enh[0]),
    .rnw_a(i_rnw[0]), .oe_n_a(i_oe_n[0]), .pipe_a(i_pipe[0]), .wdata_a(i_wd[0]),
    .rdata_a(o_rd[0]), .rdrive_a(o_drv[0]),
    .clk_b(clk), .addr_b(i_addr[1]), .ld_n_b(i_ld_n[1]), .step_n_b(i_step_n[1]),
    .clr_n_b(i_clr_n[1]), .en_lo_n_b(i_enl_n[1]), .en_hi_b(i_enh[1]),
    .rnw_b(i_rnw[1]), .oe_n_b(i_oe_n[1]), .pipe_b(i_pipe[1]), .wdata_b(i_wd[1]),
    .rdata_b(o_rd[1]), .rdrive_b(o_drv[1])
  );

  // Reference model
  int  m_mem [WORDS];
  bit  m_known [WORDS];
  int  m_ptr [2], m_wd [2], m_dq [2];
  bit  m_sel [2], m_rnw [2], m_vld [2], m_dqk [2];
  int  m_sync;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;
  string req [2];

  always @(posedge clk) begin
    int w [2];
    bit wk [2];
    bit run, clash;
    if (!arst_n) begin
      m_sync = 0;
      for (int p = 0; p < 2; p++) begin
        m_ptr[p] = 0; m_sel[p] = 0; m_rnw[p] = 1; m_vld[p] = 0;
      end
    end else begin
      run = (m_sync >= 2);
      if (m_sync < 2) m_sync++;
      for (int p = 0; p < 2; p++) begin
        w[p]  = m_mem[m_ptr[p]];
        wk[p] = m_known[m_ptr[p]];
      end
      clash = m_sel[0] && !m_rnw[0] && m_sel[1] && !m_rnw[1] && (m_ptr[0] == m_ptr[1]);
      for (int p = 0; p < 2; p++) begin
        if (m_sel[p] && !m_rnw[p]) begin
          m_mem[m_ptr[p]]   = m_wd[p];
          m_known[m_ptr[p]] = !clash;
        end
      end
      for (int p = 0; p < 2; p++) begin
        if (!run) begin
          m_ptr[p] = 0; m_sel[p] = 0; m_rnw[p] = 1; m_vld[p] = 0;
        end else begin
          if (m_sel[p] && m_rnw[p]) begin
            m_dq[p]  = w[p];
            m_dqk[p] = wk[p];
          end
          m_vld[p] = m_sel[p] && m_rnw[p];
          if (!i_clr_n[p])       m_ptr[p] = 0;
          else if (!i_ld_n[p])   m_ptr[p] = int'(i_addr[p]);
          else if (!i_step_n[p]) m_ptr[p] = (m_ptr[p] + 1) % WORDS;
          m_sel[p] = !i_enl_n[p] && i_enh[p];
          m_rnw[p] = i_rnw[p];
          if (m_sel[p] && !m_rnw[p]) m_wd[p] = int'(i_wd[p]);
        end
      end
    end
  end

  task automatic check(string r, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int p = 0; p < 2; p++) begin
      bit ev, ed, ek;
      int ex;
      ev = i_pipe[p] ? m_vld[p] : (m_sel[p] && m_rnw[p]);
      ed = ev && !i_oe_n[p];
      check(req[p], $sformatf("port%0d rdrive", p), int'(o_drv[p]), int'(ed));
      if (ed) begin
        ex = i_pipe[p] ? m_dq[p] : m_mem[m_ptr[p]];
        ek = i_pipe[p] ? m_dqk[p] : m_known[m_ptr[p]];
        if (ek) check(req[p], $sformatf("port%0d rdata", p), int'(o_rd[p]), ex);
      end else begin
        check(req[p], $sformatf("port%0d idle rdata", p), int'(o_rd[p]), 0);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic drive(int p, bit ld, bit stp, bit clr, bit sel, bit rd, int a, int wd);
    i_ld_n[p]   = !ld;
    i_step_n[p] = !stp;
    i_clr_n[p]  = !clr;
    i_enl_n[p]  = !sel;
    i_enh[p]    = 1'b1;
    i_rnw[p]    = rd;
    i_addr[p]   = AW'(a);
    i_wd[p]     = DW'(wd);
  endtask

  task automatic idle(int p);
    drive(p, 0, 0, 0, 0, 1, 0, 0);
  endtask

  function automatic int pat(int i, int s);
    return (i * 37 + s) % 256;
  endfunction

  initial begin
    arst_n = 1'b0;
    for (int p = 0; p < 2; p++) begin
      idle(p);
      i_oe_n[p] = 1'b0;
      i_pipe[p] = 1'b0;
    end
    // R10: reset state
    req[0] = "R10"; req[1] = "R10";
    repeat (3) tick();
    arst_n = 1'b1;
    // R10: port B asks for a read during the release window
    drive(1, 1, 0, 0, 1, 1, 9, 0);
    repeat (4) tick();
    idle(1);
    repeat (2) tick();

    // R1: fill the array through port A
    req[0] = "R1"; req[1] = "R9";
    drive(0, 1, 0, 0, 1, 0, 0, pat(0, 11)); tick();
    for (int i = 1; i < WORDS; i++) begin
      drive(0, 0, 1, 0, 1, 0, 0, pat(i, 11));
      tick();
    end
    idle(0);
    repeat (2) tick();

    // R7 on A (pipelined, crossing the top), R6 on B (flow-through)
    i_pipe[0] = 1'b1;
    req[0] = "R7"; req[1] = "R6";
    drive(0, 1, 0, 0, 1, 1, 240, 0);
    drive(1, 1, 0, 0, 1, 1, 10, 0);
    tick();
    for (int i = 0; i < 30; i++) begin
      drive(0, 0, 1, 0, 1, 1, 0, 0);
      drive(1, 0, 1, 0, 1, 1, 0, 0);
      tick();
    end
    idle(0); idle(1);
    repeat (2) tick();

    // R4: wrap on flow-through B, then hold
    req[1] = "R4";
    drive(1, 1, 0, 0, 1, 1, WORDS - 2, 0); tick();
    for (int i = 0; i < 4; i++) begin drive(1, 0, 1, 0, 1, 1, 0, 0); tick(); end
    drive(1, 1, 0, 0, 1, 1, 5, 0); tick();
    for (int i = 0; i < 4; i++) begin drive(1, 0, 0, 0, 1, 1, 0, 0); tick(); end

    // R5: clear beats load and step
    req[1] = "R5";
    drive(1, 1, 1, 1, 1, 1, 77, 0); tick();
    for (int i = 0; i < 3; i++) begin drive(1, 0, 0, 0, 1, 1, 0, 0); tick(); end
    // R3: load beats step
    req[1] = "R3";
    drive(1, 1, 1, 0, 1, 1, 33, 0); tick();
    for (int i = 0; i < 3; i++) begin drive(1, 0, 0, 0, 1, 1, 0, 0); tick(); end
    idle(1);
    repeat (2) tick();

    // R2: A writes a burst while B reads the same words (flow, then pipelined)
    i_pipe[0] = 1'b0;
    req[0] = "R2"; req[1] = "R2";
    for (int pm = 0; pm < 2; pm++) begin
      i_pipe[1] = pm[0];
      drive(0, 1, 0, 0, 1, 0, 50, pat(50, 90 + pm));
      drive(1, 1, 0, 0, 1, 1, 50, 0);
      tick();
      for (int i = 1; i < 8; i++) begin
        drive(0, 0, 1, 0, 1, 0, 0, pat(50 + i, 90 + pm));
        drive(1, 0, 1, 0, 1, 1, 0, 0);
        tick();
      end
      idle(0); idle(1);
      repeat (2) tick();
    end

    // R11: both ports write different bursts at once, then cross read back
    req[0] = "R11"; req[1] = "R11";
    drive(0, 1, 0, 0, 1, 0, 100, pat(100, 5));
    drive(1, 1, 0, 0, 1, 0, 150, pat(150, 6));
    tick();
    for (int i = 1; i < 8; i++) begin
      drive(0, 0, 1, 0, 1, 0, 0, pat(100 + i, 5));
      drive(1, 0, 1, 0, 1, 0, 0, pat(150 + i, 6));
      tick();
    end
    idle(0); idle(1);
    repeat (2) tick();
    drive(0, 1, 0, 0, 1, 1, 150, 0);
    drive(1, 1, 0, 0, 1, 1, 100, 0);
    tick();
    for (int i = 0; i < 9; i++) begin
      drive(0, 0, 1, 0, 1, 1, 0, 0);
      drive(1, 0, 1, 0, 1, 1, 0, 0);
      tick();
    end
    idle(0); idle(1);
    repeat (2) tick();

    // R1: both ports read the same word together
    req[0] = "R1"; req[1] = "R1";
    drive(0, 1, 0, 0, 1, 1, 42, 0);
    drive(1, 1, 0, 0, 1, 1, 42, 0);
    repeat (3) tick();
    idle(0); idle(1);
    repeat (2) tick();

    // R8: writes with one enable off each, then reads while deselected
    req[0] = "R8"; req[1] = "R8";
    drive(0, 1, 0, 0, 1, 0, 60, 170);
    i_enl_n[0] = 1'b1; tick();
    drive(0, 1, 0, 0, 1, 0, 61, 85);
    i_enh[0] = 1'b0; tick();
    drive(0, 1, 0, 0, 1, 1, 60, 0);
    i_enh[0] = 1'b0; repeat (2) tick();
    idle(0);
    drive(1, 1, 0, 0, 1, 1, 60, 0); tick();
    drive(1, 0, 1, 0, 1, 1, 0, 0); repeat (2) tick();
    idle(1);
    repeat (2) tick();

    // R9: output enable toggled during held reads, both modes
    req[0] = "R9"; req[1] = "R9";
    for (int pm = 0; pm < 2; pm++) begin
      i_pipe[1] = pm[0];
      drive(1, 1, 0, 0, 1, 1, 70 + pm, 0);
      i_oe_n[1] = 1'b1; repeat (3) tick();
      i_oe_n[1] = 1'b0; @(negedge clk); compare();
      repeat (2) tick();
      i_oe_n[1] = 1'b1; @(negedge clk); compare();
      i_oe_n[1] = 1'b0;
      idle(1);
      repeat (3) tick();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule